// File: doc/BRIEF.md
# Trigger-Relative Capture-Compare Timer

This block is a free-running up counter with one capture register, two compare registers and an output flip-flop. The counter advances only on cycles where a prescaler tick enable is high. A rising edge on the external trigger input stores the current count in the capture register. Software can then place the two compare values at fixed offsets from the captured count. When toggling is enabled, each compare match inverts the flip-flop. The output therefore rises after a chosen delay and falls after a chosen width: a one-shot pulse positioned relative to the trigger.

A second mode inverts the flip-flop directly at the capture event. This gives a pulse that starts with no delay; software then programs only the falling-edge compare. The block raises three single-cycle request pulses, each gated by its own enable: one for the capture event and one for each compare match. It holds control bits and register values, and software reaches them through a small write/read bus.

Top module: `cct_timer`

## Requirements
- R1: While running, the counter increments by one on every clock where `tick` is high and holds otherwise. It wraps from 0xFFFF to 0x0000. Its value reads at address 4.
- R2: Control bit 0 (run) held at 0 freezes the counter. A control write at address 0 that sets run while it is clear resets the counter to zero. Writing run=1 while already running leaves the count alone.
- R3: The trigger passes through two synchronizer flops. On the third clock edge after `trig_in` is first sampled high, the capture register (address 3) loads the count present in the cycle before that edge.
- R4: `irq_cap` pulses for exactly one cycle, together with the capture load, when control bit 4 is set. When bit 4 is clear it stays low, and the capture still occurs.
- R5: A control write with bit 3 set forces `ff_out` to 0 on the next edge, whatever toggle events occur in that cycle. Bit 3 is not stored.
- R6: With toggle-enable (control bit 1) set, a tick that moves the counter onto the value of compare 0 (address 1) or compare 1 (address 2) inverts `ff_out` on that same edge. With bit 1 clear, matches leave `ff_out` unchanged. The starting value zero after a start write is not a match.
- R7: When both compare registers match on the same tick, `ff_out` inverts once for each, so it ends unchanged.
- R8: `irq_cmp0` and `irq_cmp1` each pulse for one cycle on their own compare match, gated by control bits 5 and 6 respectively. They are independent of toggle-enable.
- R9: With capture-toggle (control bit 2) set, `ff_out` inverts on the same edge that loads the capture register.
- R10: Address 0 reads back run, toggle-enable, capture-toggle and the three interrupt enables at bits 0, 1, 2, 4, 5 and 6. It reads 0 at bit 3 and the flip-flop state at bit 7. Compare registers read back what was written. All registers and outputs are zero after reset.
- R11: Compare 0 = capture + D and compare 1 = compare 0 + W, with toggling on and the tick continuous, yield `ff_out` high for exactly W cycles. The output rises on the D-th tick after the captured count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler count enable |
| trig_in | input | 1 | External trigger, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 ctrl, 1 cmp0, 2 cmp1) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address (0 ctrl, 1 cmp0, 2 cmp1, 3 capture, 4 count) |
| rd_data | output | 16 | Read data, combinational |
| ff_out | output | 1 | Timer flip-flop output |
| irq_cap | output | 1 | Capture-event request pulse |
| irq_cmp0 | output | 1 | Compare 0 match request pulse |
| irq_cmp1 | output | 1 | Compare 1 match request pulse |

## Verification
On every cycle, the assertions check the following: the counter advances by one per tick and freezes while stopped, a start write zeroes it, a force-clear write drives the output low, the output is steady when no toggle source is active, and the capture request is a lone pulse that only appears when enabled. Some behaviour only the bench scenarios can show. These are the exact capture latency through the synchronizer, the parity effect of coincident matches, wrap-around matching at zero, and the delayed one-shot's width measured end to end from a trigger edge.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int NUM_CMP = 2;
    localparam int A_CTRL = 0;
    localparam int A_CMP0 = 1;
    localparam int A_CAP = 3;
    localparam int A_CNT = 4;
    localparam int B_RUN = 0;
    localparam int B_TGL = 1;
    localparam int B_CAPT = 2;
    localparam int B_FFCLR = 3;
    localparam int B_IECAP = 4;
    localparam int B_IEM0 = 5;
    localparam int B_FFRD = 7;
endpackage

// File: rtl/cct_trig_sync.sv
module cct_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LAST-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[LAST-1] & ~sh_q[LAST];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R4
endmodule

// File: rtl/cct_cmp_unit.sv
module cct_cmp_unit #(
    parameter int W = 16
) (
    input  logic         adv,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] cmp_val,
    output logic         hit
);
    always_comb begin
        hit = adv && (cnt_nxt == cmp_val);
    end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int ADDR_W = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              trig_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              ff_out,
    output logic              irq_cap,
    output logic              irq_cmp0,
    output logic              irq_cmp1
);
    typedef struct packed {
        logic [CNT_W-1:0]              cnt;
        logic [NUM_CMP-1:0][CNT_W-1:0] cmp;
        logic [CNT_W-1:0]              cap;
        logic                          run;
        logic                          tgl;
        logic                          capt;
        logic                          ie_cap;
        logic [NUM_CMP-1:0]            ie_m;
        logic                          ff;
        logic                          irq_c;
        logic [NUM_CMP-1:0]            irq_m;
    } state_t;

    state_t st_d, st_q;

    logic               trig_edge;
    logic               ctrl_wr;
    logic               start;
    logic               adv;
    logic               ff_clr;
    logic [CNT_W-1:0]   cnt_nxt;
    logic [NUM_CMP-1:0] hits;

    cct_trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (trig_in),
        .rise (trig_edge)
    );

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        start   = ctrl_wr && wr_data[B_RUN] && !st_q.run;
        adv     = st_q.run && tick && !start;
        ff_clr  = ctrl_wr && wr_data[B_FFCLR];
        cnt_nxt = st_q.cnt + CNT_W'(1);
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
            cct_cmp_unit #(.W(CNT_W)) cmp_i (
                .adv    (adv),
                .cnt_nxt(cnt_nxt),
                .cmp_val(st_q.cmp[gi]),
                .hit    (hits[gi])
            );
        end
    endgenerate

    always_comb begin
        logic flip;
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.run    = wr_data[B_RUN];
            st_d.tgl    = wr_data[B_TGL];
            st_d.capt   = wr_data[B_CAPT];
            st_d.ie_cap = wr_data[B_IECAP];
            for (int i = 0; i < NUM_CMP; i++) st_d.ie_m[i] = wr_data[B_IEM0 + i];
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(A_CMP0 + i))) st_d.cmp[i] = wr_data;
        end
        if (start)    st_d.cnt = '0;
        else if (adv) st_d.cnt = cnt_nxt;
        if (trig_edge) st_d.cap = st_q.cnt;
        flip = (^(hits & {NUM_CMP{st_q.tgl}})) ^ (st_q.capt & trig_edge);
        if (ff_clr) st_d.ff = 1'b0;
        else        st_d.ff = st_q.ff ^ flip;
        st_d.irq_c = trig_edge & st_q.ie_cap;
        st_d.irq_m = hits & st_q.ie_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_CTRL): begin
                rd_data[B_RUN]   = st_q.run;
                rd_data[B_TGL]   = st_q.tgl;
                rd_data[B_CAPT]  = st_q.capt;
                rd_data[B_IECAP] = st_q.ie_cap;
                for (int i = 0; i < NUM_CMP; i++) rd_data[B_IEM0 + i] = st_q.ie_m[i];
                rd_data[B_FFRD]  = st_q.ff;
            end
            ADDR_W'(A_CMP0):     rd_data = st_q.cmp[0];
            ADDR_W'(A_CMP0 + 1): rd_data = st_q.cmp[1];
            ADDR_W'(A_CAP):      rd_data = st_q.cap;
            ADDR_W'(A_CNT):      rd_data = st_q.cnt;
            default:             rd_data = '0;
        endcase
    end

    assign ff_out   = st_q.ff;
    assign irq_cap  = st_q.irq_c;
    assign irq_cmp0 = st_q.irq_m[0];
    assign irq_cmp1 = st_q.irq_m[1];

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !start) |=> $stable(st_q.cnt)); // R2
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.cnt == '0)); // R2
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && tick && !start) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1))); // R1
    AST_FF_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        ff_clr |=> !ff_out); // R5
    AST_FF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.tgl && !(st_q.capt && trig_edge) && !ff_clr) |=> $stable(ff_out)); // R6
    AST_CAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ie_cap |=> !irq_cap); // R4
endmodule

// File: tb/cct_timer_tb.sv
module cct_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        trig_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ff_out, irq_cap, irq_cmp0, irq_cmp1;

    int checks = 0;
    int fails = 0;
    int n_cap = 0, n_m0 = 0, n_m1 = 0, n_hi = 0;
    logic mon_en = 1'b0;

    always #10 clk = ~clk;

    cct_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig_in(trig_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ff_out(ff_out),
        .irq_cap(irq_cap), .irq_cmp0(irq_cmp0), .irq_cmp1(irq_cmp1)
    );

    always @(negedge clk) begin
        if (irq_cap)  n_cap <= n_cap + 1;
        if (irq_cmp0) n_m0 <= n_m0 + 1;
        if (irq_cmp1) n_m1 <= n_m1 + 1;
        if (mon_en && ff_out) n_hi <= n_hi + 1;
    end

    typedef struct packed {
        logic [15:0] c0;
        logic [15:0] c1;
        logic        tgl;
        logic [15:0] n;
        logic        ff;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'd5,  16'd10, 1'b1, 16'd7,  1'b1},
        '{16'd5,  16'd10, 1'b1, 16'd12, 1'b0},
        '{16'd5,  16'd10, 1'b0, 16'd12, 1'b0},
        '{16'd8,  16'd8,  1'b1, 16'd9,  1'b0},
        '{16'd3,  16'd50, 1'b1, 16'd20, 1'b1},
        '{16'd0,  16'd2,  1'b1, 16'd2,  1'b1},
        '{16'd1,  16'd1,  1'b0, 16'd5,  1'b0}
    };

    function automatic logic [15:0] ctl(input logic run, tgl, capt, clr, iec, ie0, ie1);
        logic [15:0] v = '0;
        v[0] = run; v[1] = tgl; v[2] = capt; v[3] = clr;
        v[4] = iec; v[5] = ie0; v[6] = ie1;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick = 1'b1;
            repeat (n) @(posedge clk);
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic trigger();
        @(negedge clk);
        trig_in = 1'b1;
        repeat (5) @(negedge clk);
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] r;
        logic [15:0] c;
        int s0, s1, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk("R10 reset ff", {31'd0, ff_out}, 0);
        chk("R10 reset irqs", {29'd0, irq_cap, irq_cmp0, irq_cmp1}, 0);
        rd(3'd0, r); chk("R10 reset ctrl", {16'd0, r}, 0);
        rd(3'd3, r); chk("R10 reset cap", {16'd0, r}, 0);
        rd(3'd4, r); chk("R10 reset cnt", {16'd0, r}, 0);

        // Vector table: R6, R7, R1
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, ctl(0, 0, 0, 1, 0, 0, 0));
            wr(3'd1, VECS[i].c0);
            wr(3'd2, VECS[i].c1);
            wr(3'd0, ctl(1, VECS[i].tgl, 0, 0, 0, 0, 0));
            ticks(int'(VECS[i].n));
            rd(3'd4, r); chk("R1 vector count", {16'd0, r}, {16'd0, VECS[i].n});
            chk("R6 R7 vector ff", {31'd0, ff_out}, {31'd0, VECS[i].ff});
        end

        // R10 readback
        wr(3'd0, ctl(0, 1, 1, 1, 1, 0, 1));
        rd(3'd0, r); chk("R10 ctrl readback", {16'd0, r}, 32'h0056);
        wr(3'd1, 16'hA5C3);
        rd(3'd1, r); chk("R10 cmp0 readback", {16'd0, r}, 32'hA5C3);

        // R2 hold and restart
        wr(3'd0, ctl(0, 0, 0, 1, 0, 0, 0));
        wr(3'd1, 16'hF000); wr(3'd2, 16'hF000);
        wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 0));
        ticks(5);
        wr(3'd0, ctl(0, 0, 0, 0, 0, 0, 0));
        ticks(5);
        rd(3'd4, r); chk("R2 stopped hold", {16'd0, r}, 5);
        wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 0));
        rd(3'd4, r); chk("R2 start clears", {16'd0, r}, 0);
        ticks(3);
        wr(3'd0, ctl(1, 1, 0, 0, 0, 0, 0));
        rd(3'd4, r); chk("R2 run rewrite keeps", {16'd0, r}, 3);

        // R3 R4 capture with irq enabled
        ticks(4);
        wr(3'd0, ctl(1, 0, 0, 0, 1, 0, 0));
        s0 = n_cap;
        trigger();
        rd(3'd3, r); chk("R3 capture value", {16'd0, r}, 7);
        chk("R4 capture irq once", n_cap - s0, 1);
        // R3 latency: cap loads on third edge after trig sampled high
        ticks(2);
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); @(negedge clk);
        rd_addr = 3'd3; #1 chk("R3 not yet loaded", {16'd0, rd_data}, 7);
        @(negedge clk); #1 chk("R3 loaded third edge", {16'd0, rd_data}, 9);
        @(negedge clk); trig_in = 1'b0;
        repeat (3) @(negedge clk);
        // R4 disabled
        wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 0));
        ticks(2);
        s0 = n_cap;
        trigger();
        chk("R4 capture irq masked", n_cap - s0, 0);
        rd(3'd3, r); chk("R4 capture still loads", {16'd0, r}, 11);

        // R9 capture toggle, R5 forced clear, R6 disabled keeps 1
        wr(3'd0, ctl(1, 0, 1, 1, 0, 0, 0));
        trigger();
        chk("R9 capture toggles ff", {31'd0, ff_out}, 1);
        rd(3'd4, c);
        wr(3'd1, c + 16'd2);
        wr(3'd0, ctl(1, 0, 0, 0, 0, 1, 0));
        s1 = n_m0;
        ticks(4);
        chk("R6 disabled keeps ff", {31'd0, ff_out}, 1);
        chk("R8 cmp0 irq without toggle", n_m0 - s1, 1);
        wr(3'd0, ctl(1, 0, 0, 1, 0, 0, 0));
        chk("R5 forced clear", {31'd0, ff_out}, 0);

        // R1 wrap, matching at zero
        wr(3'd0, ctl(0, 0, 0, 1, 0, 0, 0));
        wr(3'd1, 16'h0000); wr(3'd2, 16'hFFFF);
        wr(3'd0, ctl(1, 1, 0, 0, 0, 0, 0));
        ticks(65535);
        rd(3'd4, r); chk("R1 count at top", {16'd0, r}, 32'hFFFF);
        chk("R6 ff at top", {31'd0, ff_out}, 1);
        ticks(1);
        rd(3'd4, r); chk("R1 wrap to zero", {16'd0, r}, 0);
        chk("R6 match at wrap", {31'd0, ff_out}, 0);

        // R11 delayed one-shot, R8 gating
        wr(3'd0, ctl(1, 0, 0, 1, 0, 0, 0));
        ticks(20);
        trigger();
        rd(3'd3, c);
        wr(3'd1, c + 16'd3);
        wr(3'd2, c + 16'd7);
        wr(3'd0, ctl(1, 1, 0, 0, 0, 0, 1));
        s0 = n_hi; s1 = n_m0; s2 = n_m1;
        @(negedge clk); mon_en = 1'b1;
        ticks(12);
        @(negedge clk); mon_en = 1'b0;
        wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 1));
        chk("R11 pulse width", n_hi - s0, 4);
        chk("R11 pulse ended", {31'd0, ff_out}, 0);
        chk("R8 cmp1 irq once", n_m1 - s2, 1);
        chk("R8 cmp0 irq masked", n_m0 - s1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule